// File: doc/BRIEF.md
# Stereo Volume, Mute and Channel Mix Stage

This block is the per-sample digital gain stage in front of a stereo converter's interpolation path. Each time the sample strobe is high, it takes one signed left sample and one signed right sample. For each of the two outputs it picks a source: zero, right, left, or the floored average of both. It then scales that source by a gain chosen from a 1 dB attenuation index, and registers the result.

Each output has its own 8-bit volume setting: a mute flag and a 7-bit attenuation. A shared 2-bit change mode sets how a new setting reaches the applied gain:
- at once;
- held until the routed signal changes sign, or until a sample timeout;
- ramped one index step per sample;
- ramped one step per sign change or timeout.

An optional auto-mute watch raises a flag and forces both outputs to zero once both inputs have stayed at zero for a configurable run of samples.

Top module: `stereo_vol_mix`

## Requirements
- R1: `out_vld` is high in exactly the cycle after each cycle with `smp_vld` high. `out_a`, `out_b` and `amuted` change only in that cycle.
- R2: `route_sel[3:2]` picks the source for output A and `route_sel[1:0]` the source for output B. Code 00 gives zero, 01 gives right, 10 gives left, and 11 gives floor((L+R)/2).
- R3: Volume bits [6:0] give an attenuation index n in dB steps. Gain = B[n mod 6] >> (n div 6), where B = {32768, 29205, 26029, 23198, 20675, 18427}. The output is floor(source × gain / 32768).
- R4: Volume bit 7 set makes the target index 127, which gives a gain of zero. The target is reached through the selected change mode.
- R5: With change mode 00, the applied index equals the target, and it is used already for the sample presented with the new setting.
- R6: With change mode 01, a differing target is applied on the first sample whose routed source sign differs from that output's previous sample sign (sign = source bit W-1). If no sign change occurs, it is applied on the ZC_TIMEOUT-th consecutive pending sample.
- R7: With change mode 10, the applied index moves one step toward the target on every sample.
- R8: With change mode 11, the applied index moves one step toward the target only on a sample that meets the R6 sign-change or timeout condition. The timeout count restarts after each step.
- R9: When `amute_en` is set and a sample is the ZERO_RUN-th consecutive sample with both inputs zero, `amuted` rises with that sample's output, and outputs stay zero while it holds. The first sample with a non-zero input clears `amuted` and is passed normally. When `amute_en` is clear, `amuted` stays low.
- R10: After reset: `out_vld`, `out_a`, `out_b` and `amuted` are zero, the applied index of both outputs is 0 (0 dB), both previous signs are non-negative, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_l | input | W | Left sample, two's complement |
| smp_r | input | W | Right sample, two's complement |
| route_sel | input | 4 | Source codes: [3:2] for output A, [1:0] for output B |
| chg_mode | input | 2 | Change mode: 00 immediate, 01 sign-change gated, 10 ramp, 11 gated ramp |
| vol_a | input | 8 | Output A volume: bit 7 mute, [6:0] attenuation |
| vol_b | input | 8 | Output B volume: bit 7 mute, [6:0] attenuation |
| amute_en | input | 1 | Auto-mute enable |
| out_vld | output | 1 | Output strobe |
| out_a | output | W | Scaled output A |
| out_b | output | W | Scaled output B |
| amuted | output | 1 | Auto-mute active |

## Verification
Every scaled output and the auto-mute flag are due exactly one clock after the edge that captures the sample strobe. The gain index used for a sample is already the updated one, so a setting change shows in that same result. The driver holds the strobe for one cycle and pushes the expected item at that moment. The monitor samples at the falling edge that follows the capture edge, so each pop meets exactly the result of the sample that pushed it. Any output strobe without a queued item, and any item left in the queue at the end, is a timing failure.

// File: rtl/svm_pkg.sv
package svm_pkg;

    localparam int ATT_W     = 7;
    localparam int GAIN_W    = 17;
    localparam int GAIN_FRAC = 15;
    localparam logic [ATT_W-1:0] MUTE_IDX = '1;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'b00,
        SRC_RIGHT = 2'b01,
        SRC_LEFT  = 2'b10,
        SRC_AVG   = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CHG_NOW     = 2'b00,
        CHG_ZC      = 2'b01,
        CHG_RAMP    = 2'b10,
        CHG_RAMP_ZC = 2'b11
    } chg_e;

    typedef struct packed {
        logic             mute;
        logic [ATT_W-1:0] att;
    } vol_t;

    // 1 dB steps within one octave, halved per 6 dB
    function automatic logic [GAIN_W-1:0] att_to_gain(input logic [ATT_W-1:0] n);
        logic [ATT_W-1:0]  oct;
        logic [ATT_W-1:0]  frac;
        logic [GAIN_W-1:0] base;
        oct  = n / ATT_W'(6);
        frac = n - ATT_W'(oct * ATT_W'(6));
        case (frac)
            ATT_W'(0): base = GAIN_W'(32768);
            ATT_W'(1): base = GAIN_W'(29205);
            ATT_W'(2): base = GAIN_W'(26029);
            ATT_W'(3): base = GAIN_W'(23198);
            ATT_W'(4): base = GAIN_W'(20675);
            default:   base = GAIN_W'(18427);
        endcase
        return base >> oct;
    endfunction

    function automatic logic [ATT_W-1:0] step_toward(input logic [ATT_W-1:0] cur,
                                                     input logic [ATT_W-1:0] tgt);
        if (cur < tgt)      return cur + ATT_W'(1);
        else if (cur > tgt) return cur - ATT_W'(1);
        else                return cur;
    endfunction

endpackage

// File: rtl/svm_route.sv
module svm_route
    import svm_pkg::*;
#(
    parameter int W = 24
) (
    input  src_e               sel,
    input  logic signed [W-1:0] l,
    input  logic signed [W-1:0] r,
    output logic signed [W-1:0] mix
);
    logic signed [W:0] sum;

    always_comb begin
        sum = {l[W-1], l} + {r[W-1], r};
        mix = '0;
        unique case (sel)
            SRC_ZERO:  mix = '0;
            SRC_RIGHT: mix = r;
            SRC_LEFT:  mix = l;
            default:   mix = W'(sum >>> 1);
        endcase
    end
endmodule

// File: rtl/svm_gain_ctrl.sv
module svm_gain_ctrl
    import svm_pkg::*;
#(
    parameter int ZC_TIMEOUT = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  chg_e             mode,
    input  vol_t             tgt,
    input  logic             sgn,
    output logic [ATT_W-1:0] use_idx,
    output logic [ATT_W-1:0] held_idx
);
    localparam int CW = $clog2(ZC_TIMEOUT + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(ZC_TIMEOUT - 1);

    logic [ATT_W-1:0] cur_q;
    logic [ATT_W-1:0] tgt_idx;
    logic [ATT_W-1:0] stepped;
    logic             prev_neg_q;
    logic [CW-1:0]    wait_q;
    logic             pending;
    logic             gate;

    always_comb begin
        tgt_idx = tgt.mute ? MUTE_IDX : tgt.att;
        pending = (tgt_idx != cur_q);
        gate    = (sgn != prev_neg_q) || (wait_q == CNT_LAST);
        stepped = step_toward(cur_q, tgt_idx);
        unique case (mode)
            CHG_NOW:  use_idx = tgt_idx;
            CHG_ZC:   use_idx = gate ? tgt_idx : cur_q;
            CHG_RAMP: use_idx = stepped;
            default:  use_idx = gate ? stepped : cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            prev_neg_q <= 1'b0;
            wait_q     <= '0;
        end else if (stb) begin
            cur_q      <= use_idx;
            prev_neg_q <= sgn;
            if (!mode[0] || !pending || gate) wait_q <= '0;
            else                              wait_q <= wait_q + CW'(1);
        end
    end

    assign held_idx = cur_q;
endmodule

// File: rtl/svm_scale.sv
module svm_scale
    import svm_pkg::*;
#(
    parameter int W = 24
) (
    input  logic signed [W-1:0] mix,
    input  logic [ATT_W-1:0]    idx,
    output logic signed [W-1:0] scaled
);
    localparam int PW = W + GAIN_W + 1;

    logic [GAIN_W-1:0]   g;
    logic signed [PW-1:0] prod;

    always_comb begin
        g      = att_to_gain(idx);
        prod   = PW'(mix) * PW'($signed({1'b0, g}));
        scaled = W'(prod >>> GAIN_FRAC);
    end
endmodule

// File: rtl/svm_zero_watch.sv
module svm_zero_watch #(
    parameter int ZERO_RUN = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic en,
    input  logic all_zero,
    output logic mute_now
);
    localparam int CW = $clog2(ZERO_RUN + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(ZERO_RUN - 1);

    logic [CW-1:0] run_q;

    assign mute_now = en && all_zero && (run_q >= RUN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (stb) begin
            if (!all_zero)            run_q <= '0;
            else if (run_q < RUN_LAST) run_q <= run_q + CW'(1);
        end
    end
endmodule

// File: rtl/stereo_vol_mix.sv
module stereo_vol_mix
    import svm_pkg::*;
#(
    parameter int W          = 24,
    parameter int ZC_TIMEOUT = 512,
    parameter int ZERO_RUN   = 8192
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld,
    input  logic signed [W-1:0] smp_l,
    input  logic signed [W-1:0] smp_r,
    input  logic [3:0]          route_sel,
    input  logic [1:0]          chg_mode,
    input  logic [7:0]          vol_a,
    input  logic [7:0]          vol_b,
    input  logic                amute_en,
    output logic                out_vld,
    output logic signed [W-1:0] out_a,
    output logic signed [W-1:0] out_b,
    output logic                amuted
);
    localparam int NCH = 2;

    src_e                src      [NCH];
    vol_t                vcfg     [NCH];
    logic signed [W-1:0] mix      [NCH];
    logic signed [W-1:0] scaled   [NCH];
    logic [ATT_W-1:0]    use_idx  [NCH];
    logic [ATT_W-1:0]    held_idx [NCH];
    chg_e                mode;
    logic                mute_now;

    assign src[0]  = src_e'(route_sel[3:2]);
    assign src[1]  = src_e'(route_sel[1:0]);
    assign vcfg[0] = vol_t'(vol_a);
    assign vcfg[1] = vol_t'(vol_b);
    assign mode    = chg_e'(chg_mode);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        svm_route #(.W(W)) u_route (
            .sel (src[c]),
            .l   (smp_l),
            .r   (smp_r),
            .mix (mix[c])
        );
        svm_gain_ctrl #(.ZC_TIMEOUT(ZC_TIMEOUT)) u_gain (
            .clk      (clk),
            .rst      (rst),
            .stb      (smp_vld),
            .mode     (mode),
            .tgt      (vcfg[c]),
            .sgn      (mix[c][W-1]),
            .use_idx  (use_idx[c]),
            .held_idx (held_idx[c])
        );
        svm_scale #(.W(W)) u_scale (
            .mix    (mix[c]),
            .idx    (use_idx[c]),
            .scaled (scaled[c])
        );
    end

    svm_zero_watch #(.ZERO_RUN(ZERO_RUN)) u_zero (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_vld),
        .en       (amute_en),
        .all_zero ((smp_l == '0) && (smp_r == '0)),
        .mute_now (mute_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_a   <= '0;
            out_b   <= '0;
            amuted  <= 1'b0;
        end else begin
            out_vld <= smp_vld;
            if (smp_vld) begin
                amuted <= mute_now;
                out_a  <= mute_now ? '0 : scaled[0];
                out_b  <= mute_now ? '0 : scaled[1];
            end
        end
    end
endmodule

// File: rtl/svm_checker.sv
module svm_checker #(
    parameter int W = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_vld,
    input logic signed [W-1:0] smp_l,
    input logic [3:0]          route_sel,
    input logic [1:0]          chg_mode,
    input logic [7:0]          vol_a,
    input logic                out_vld,
    input logic signed [W-1:0] out_a,
    input logic signed [W-1:0] out_b,
    input logic                amuted,
    input logic [6:0]          held_a
);
    // R1
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> out_vld);

    // R1
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> !out_vld);

    // R2
    route_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && route_sel[3:2] == 2'b00) |=> (out_a == '0));

    // R5
    unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && chg_mode == 2'b00 && vol_a == 8'h00 && route_sel[3:2] == 2'b10)
        |=> (out_a == $past(smp_l)));

    // R7
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && chg_mode == 2'b10)
        |=> (held_a == $past(held_a) || held_a == $past(held_a) + 7'd1
             || held_a == $past(held_a) - 7'd1));

    // R9
    amute_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && amuted) |-> (out_a == '0 && out_b == '0));
endmodule

bind stereo_vol_mix svm_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld   (smp_vld),
    .smp_l     (smp_l),
    .route_sel (route_sel),
    .chg_mode  (chg_mode),
    .vol_a     (vol_a),
    .out_vld   (out_vld),
    .out_a     (out_a),
    .out_b     (out_b),
    .amuted    (amuted),
    .held_a    (held_idx[0])
);

// File: tb/sim_stereo_vol_mix.sv
module sim_stereo_vol_mix;
    localparam int W  = 16;
    localparam int TO = 8;
    localparam int ZR = 12;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                smp_vld = 1'b0;
    logic signed [W-1:0] smp_l = '0;
    logic signed [W-1:0] smp_r = '0;
    logic [3:0]          route_sel = 4'b1001;
    logic [1:0]          chg_mode = 2'b00;
    logic [7:0]          vol_a = 8'h00;
    logic [7:0]          vol_b = 8'h00;
    logic                amute_en = 1'b0;
    logic                out_vld;
    logic signed [W-1:0] out_a;
    logic signed [W-1:0] out_b;
    logic                amuted;

    int total = 0;
    int bad   = 0;
    string tag = "R10";

    typedef struct {
        int    a;
        int    b;
        bit    am;
        string tag;
    } item_t;
    item_t q[$];

    int m_cur[2]     = '{0, 0};
    int m_prevneg[2] = '{0, 0};
    int m_wait[2]    = '{0, 0};
    int m_zrun       = 0;

    always #4 clk = ~clk;

    stereo_vol_mix #(.W(W), .ZC_TIMEOUT(TO), .ZERO_RUN(ZR)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .route_sel(route_sel), .chg_mode(chg_mode), .vol_a(vol_a), .vol_b(vol_b),
        .amute_en(amute_en), .out_vld(out_vld), .out_a(out_a), .out_b(out_b),
        .amuted(amuted)
    );

    // R3 gain rule
    function automatic longint gain_of(int n);
        longint b;
        case (n % 6)
            0: b = 32768;
            1: b = 29205;
            2: b = 26029;
            3: b = 23198;
            4: b = 20675;
            default: b = 18427;
        endcase
        return b >> (n / 6);
    endfunction

    task automatic model(input int l, input int r, output item_t it);
        int res[2];
        bit allz;
        bit mnow;
        for (int c = 0; c < 2; c++) begin
            int code, mix, tgt, nxt, stp;
            bit neg, gate;
            logic [7:0] v;
            code = (c == 0) ? int'(route_sel[3:2]) : int'(route_sel[1:0]);
            case (code)
                0: mix = 0;
                1: mix = r;
                2: mix = l;
                default: mix = (l + r) >>> 1;
            endcase
            v    = (c == 0) ? vol_a : vol_b;
            tgt  = v[7] ? 127 : int'(v[6:0]);
            neg  = (mix < 0);
            gate = (int'(neg) != m_prevneg[c]) || (m_wait[c] == TO - 1);
            stp  = (m_cur[c] < tgt) ? m_cur[c] + 1 : (m_cur[c] > tgt) ? m_cur[c] - 1 : m_cur[c];
            case (chg_mode)
                2'b00: nxt = tgt;
                2'b01: nxt = gate ? tgt : m_cur[c];
                2'b10: nxt = stp;
                default: nxt = gate ? stp : m_cur[c];
            endcase
            if (chg_mode[0] && tgt != m_cur[c] && !gate) m_wait[c]++;
            else m_wait[c] = 0;
            m_cur[c]     = nxt;
            m_prevneg[c] = int'(neg);
            res[c] = int'((longint'(mix) * gain_of(nxt)) >>> 15);
        end
        allz = (l == 0) && (r == 0);
        mnow = amute_en && allz && (m_zrun >= ZR - 1);
        if (!allz) m_zrun = 0;
        else if (m_zrun < ZR - 1) m_zrun++;
        it.a   = mnow ? 0 : res[0];
        it.b   = mnow ? 0 : res[1];
        it.am  = mnow;
        it.tag = tag;
    endtask

    // driver: called at a falling edge
    task automatic send(input int l, input int r);
        item_t it;
        model(l, r, it);
        q.push_back(it);
        smp_l   = W'(l);
        smp_r   = W'(r);
        smp_vld = 1'b1;
        @(negedge clk);
        smp_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic check(input string t, input bit ok, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s", t, msg);
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_vld) begin
                if (q.size() == 0) begin
                    check("R1", 1'b0, "output strobe with nothing expected");
                end else begin
                    item_t e;
                    e = q.pop_front();
                    check(e.tag,
                          int'(out_a) == e.a && int'(out_b) == e.b && amuted == e.am,
                          $sformatf("actual a=%0d b=%0d am=%0d expected a=%0d b=%0d am=%0d",
                                    out_a, out_b, amuted, e.a, e.b, e.am));
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", out_vld == 1'b0 && out_a == '0 && out_b == '0 && amuted == 1'b0,
              $sformatf("actual vld=%0d a=%0d b=%0d am=%0d expected all 0",
                        out_vld, out_a, out_b, amuted));
        rst = 1'b0;
        @(negedge clk);

        // R10: first sample after reset uses 0 dB even under ramp
        tag = "R10"; chg_mode = 2'b10;
        send(1234, -4321);

        // R2 / R5 routing at 0 dB, immediate mode
        chg_mode = 2'b00; tag = "R5";
        route_sel = 4'b1001; send(1000, -2000); send(-32768, 32767);
        tag = "R2";
        route_sel = 4'b1111; send(3, -6); send(-32768, -32767);
        route_sel = 4'b1100; send(700, 301);
        route_sel = 4'b0110; send(-5, 9);
        route_sel = 4'b1101; send(-11, 4);
        route_sel = 4'b1010; send(222, -333);

        // R3 attenuation steps
        tag = "R3"; route_sel = 4'b1001;
        vol_a = 8'd6;   vol_b = 8'd20; send(20000, -20000); send(12345, 30000);
        vol_a = 8'd1;   vol_b = 8'd59; send(-32768, 32767);
        vol_a = 8'd126; vol_b = 8'd5;  send(32767, -1);

        // R4 mute bit
        tag = "R4";
        vol_a = 8'h83; vol_b = 8'h00; send(1000, 1000);
        vol_a = 8'h00; send(1000, 1000);

        // R7 ramp
        tag = "R7"; chg_mode = 2'b10;
        vol_a = 8'd10; vol_b = 8'h80;
        for (int i = 0; i < 14; i++) send(5000, -5000);
        vol_a = 8'd2;
        for (int i = 0; i < 10; i++) send(-7000, 7000);

        // R6 sign-change gating and timeout
        tag = "R6"; chg_mode = 2'b00; vol_a = 8'd0; vol_b = 8'd0;
        send(100, 100);
        chg_mode = 2'b01; vol_a = 8'd3; vol_b = 8'd3;
        for (int i = 0; i < 3; i++) send(8000, 8000);
        send(-8000, 8000);
        send(9000, 9000);
        vol_a = 8'd9; vol_b = 8'd12;
        for (int i = 0; i < 10; i++) send(9000, -9000);

        // R8 gated ramp
        tag = "R8"; chg_mode = 2'b11; vol_a = 8'd0; vol_b = 8'd4;
        for (int i = 0; i < 6; i++) send((i % 2 == 0) ? -3000 : 3000, 3000);
        for (int i = 0; i < 12; i++) send(3000, 3000);

        // R9 auto-mute
        tag = "R9"; chg_mode = 2'b00; vol_a = 8'd0; vol_b = 8'd0; amute_en = 1'b1;
        for (int i = 0; i < ZR + 2; i++) send(0, 0);
        send(7, 0);
        send(0, 0);
        amute_en = 1'b0;
        for (int i = 0; i < ZR + 2; i++) send(0, 0);

        repeat (2) @(negedge clk);
        check("R1", q.size() == 0,
              $sformatf("actual pending=%0d expected pending=0", q.size()));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule